// File: doc/BRIEF.md
# Grouped priority interrupt controller

This block collects interrupt requests from a set of groups, each group holding up to four request sources. It presents the processor with a 3-bit interrupt level and a one-cycle non-maskable pulse. Two groups are non-maskable. The remaining groups are maskable, and each of them carries a programmable 3-bit priority level and a 4-bit source enable. A lower level means a more urgent request. The level value 7 means that no interrupt is pending.

Request sources arrive as one-cycle set strobes, one strobe per source. A byte-wide register port gives access to two windows. The first is the group control window, which holds the request and enable state of each group and the level of each maskable group. The second is a read-only window that holds the group number captured on the last acknowledge. When the processor accepts an interrupt it strobes the acknowledge input together with the level it saw. The block then captures the current winning group and raises an error pulse if the two levels disagree.

Top module: `grpint_ctrl`

## Requirements
- R1: After reset, all request bits and all level fields are 0 and every enable field is 0xF. `irq_level` reads 7, and `nmi_pulse` and `ack_error` read 0.
- R2: A maskable group (2 to 24) is a candidate when its request AND enable is nonzero. `irq_level` is the smallest candidate level below 7, or 7 when there is none. A group at level 7 is never selected. The output reflects any set or write from the edge that stores it.
- R3: When candidates share the lowest level, the lowest-numbered group wins.
- R4: A high on `src_set[4*g+s]` at a clock edge sets request bit s of group g. When a set and a register write reach the same group in the same cycle, the set is applied after the write.
- R5: Byte 0 of a maskable group reads {request[3:0], request&enable[3:0]}. On a write, call the upper nibble U and the lower nibble L. For each bit: U=1 and L=1 sets the request bit, U=0 and L=1 clears it, and every other combination leaves it unchanged.
- R6: Byte 1 of a maskable group reads {0, level[2:0], enable[3:0]}, and a write loads the level and enable fields from the same positions. Bytes 2 and 3 read 0, and writes to them have no effect.
- R7: For the non-maskable groups 0 and 1, byte 0 reads {0000, request}, and writing 1s to bits 3:0 clears those request bits. Byte 1 reads 0 and ignores writes. These groups never change `irq_level`.
- R8: When a set strobe hits group 0 or 1, `nmi_pulse` is high for exactly the one cycle after that edge, provided the group's (request OR set) AND enable is nonzero. `nmi_pulse` is low in every other cycle.
- R9: In the group control window (`reg_win`=0), `reg_addr` selects group (addr/4) mod 25, and byte addr mod 4 within that group.
- R10: On `ack_valid`, the block captures the current winning maskable group. If no group is pending, it captures group 0.
- R11: `ack_error` is high for the one cycle after an acknowledge whose `ack_level` differs from `irq_level`, and is low otherwise.
- R12: In the accepted window (`reg_win`=1), offset 0 reads the captured group number times 4 when that group still has an enabled request, and reads 0 otherwise. Every other offset reads 0, and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 100 | One set strobe per source, bit 4*group+source |
| ack_valid | input | 1 | Processor accepts the presented interrupt |
| ack_level | input | 3 | Level the processor accepted |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_win | input | 1 | 0 = group control window, 1 = accepted-group window |
| reg_addr | input | 8 | Byte offset within the window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational, 0 when no read is active |
| irq_level | output | 3 | Level of the winning maskable group, 7 when none |
| nmi_pulse | output | 1 | One-cycle non-maskable request |
| ack_error | output | 1 | One-cycle acknowledge level mismatch flag |

## Verification
A set strobe, a register write or an acknowledge is captured at a single clock edge. Its effect on `irq_level`, `nmi_pulse`, `ack_error` and the stored state is therefore due just after that edge. `nmi_pulse` and `ack_error` must drop again one edge later. Read data is combinational from the stored state and the address, so the bench holds a read address for the whole cycle and samples the result 2 ns after the next edge. The driver pushes each expected value as it drives the stimulus, and the monitor pops the value at that same point, so every comparison lands on the cycle in which the result is due.

// File: rtl/grpint_pkg.sv
package grpint_pkg;
  localparam int SRCS  = 4;
  localparam int LVL_W = 3;

  typedef logic [SRCS-1:0]  src_t;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_NONE = 3'd7;

  // Byte-0 write merge for a maskable group: upper nibble qualifies, lower nibble acts
  function automatic src_t merge_req(src_t cur, logic [7:0] wd);
    src_t up;
    src_t lo;
    up = wd[7:4];
    lo = wd[3:0];
    return (up & lo) | (up & cur) | (~up & ~lo & cur);
  endfunction

  // Group index selected by a byte offset in the control window
  function automatic int unsigned addr_group(int unsigned off, int unsigned ngrp);
    return (off >> 2) % ngrp;
  endfunction

  function automatic logic [7:0] ctl_byte0(src_t req, src_t en, logic nmi);
    return nmi ? {4'b0000, req} : {req, req & en};
  endfunction

  function automatic logic [7:0] ctl_byte1(lvl_t lvl, src_t en, logic nmi);
    return nmi ? 8'h00 : {1'b0, lvl, en};
  endfunction
endpackage

// File: rtl/grpint_group.sv
module grpint_group
  import grpint_pkg::*;
#(
  parameter bit IS_NMI = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  src_t       set_i,
  input  logic       wr_b0,
  input  logic       wr_b1,
  input  logic [7:0] wdata,
  output src_t       req_o,
  output src_t       en_o,
  output lvl_t       lvl_o
);
  src_t req_next;

  // Write first, then OR in this cycle's set strobes
  always_comb begin
    if (!wr_b0)      req_next = req_o;
    else if (IS_NMI) req_next = req_o & ~wdata[3:0];
    else             req_next = merge_req(req_o, wdata);
    req_next = req_next | set_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_o <= '0;
      en_o  <= '1;
      lvl_o <= '0;
    end else begin
      req_o <= req_next;
      if (wr_b1 && !IS_NMI) begin
        lvl_o <= wdata[6:4];
        en_o  <= wdata[3:0];
      end
    end
  end
endmodule

// File: rtl/grpint_arbiter.sv
module grpint_arbiter
  import grpint_pkg::*;
#(
  parameter int N     = 25,
  parameter int FIRST = 2,
  parameter int GW    = $clog2(N)
) (
  input  src_t [N-1:0] req_i,
  input  src_t [N-1:0] en_i,
  input  lvl_t [N-1:0] lvl_i,
  output logic [N-1:0] cand_o,
  output logic [GW-1:0] win_o,
  output lvl_t         lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_cand
    assign cand_o[g] = |(req_i[g] & en_i[g]);
  end

  logic [GW-1:0] best_g;
  lvl_t          best_l;

  // Strictly-lower comparison in ascending order: ties stay with the lower index
  always_comb begin
    best_g = '0;
    best_l = LVL_NONE;
    for (int g = FIRST; g < N; g++) begin
      if (cand_o[g] && (lvl_i[g] < best_l)) begin
        best_g = GW'(g);
        best_l = lvl_i[g];
      end
    end
  end

  assign win_o = best_g;
  assign lvl_o = best_l;
endmodule

// File: rtl/grpint_regif.sv
module grpint_regif
  import grpint_pkg::*;
#(
  parameter int N     = 25,
  parameter int N_NMI = 2,
  parameter int AW    = 8,
  parameter int GW    = $clog2(N)
) (
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic          reg_win,
  input  logic [AW-1:0] reg_addr,
  input  src_t [N-1:0]  req_i,
  input  src_t [N-1:0]  en_i,
  input  lvl_t [N-1:0]  lvl_i,
  input  logic [GW-1:0] acc_i,
  output logic [N-1:0]  wr_b0,
  output logic [N-1:0]  wr_b1,
  output logic [7:0]    rdata
);
  logic [GW-1:0] sel_g;
  logic [1:0]    sel_b;
  logic          sel_nmi;

  assign sel_g   = GW'(addr_group(32'(reg_addr), N));
  assign sel_b   = reg_addr[1:0];
  assign sel_nmi = (32'(sel_g) < N_NMI);

  always_comb begin
    wr_b0 = '0;
    wr_b1 = '0;
    if (reg_en && reg_we && !reg_win) begin
      if (sel_b == 2'd0)      wr_b0[sel_g] = 1'b1;
      else if (sel_b == 2'd1) wr_b1[sel_g] = 1'b1;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (reg_en && !reg_we) begin
      if (reg_win) begin
        if ((reg_addr == '0) && (|(req_i[acc_i] & en_i[acc_i])))
          rdata = 8'({acc_i, 2'b00});
      end else begin
        case (sel_b)
          2'd0:    rdata = ctl_byte0(req_i[sel_g], en_i[sel_g], sel_nmi);
          2'd1:    rdata = ctl_byte1(lvl_i[sel_g], en_i[sel_g], sel_nmi);
          default: rdata = 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/grpint_ctrl.sv
module grpint_ctrl
  import grpint_pkg::*;
#(
  parameter int N_GROUPS = 25,
  parameter int N_NMI    = 2,
  parameter int AW       = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_GROUPS*SRCS-1:0] src_set,
  input  logic                     ack_valid,
  input  logic [LVL_W-1:0]         ack_level,
  input  logic                     reg_en,
  input  logic                     reg_we,
  input  logic                     reg_win,
  input  logic [AW-1:0]            reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  output logic [LVL_W-1:0]         irq_level,
  output logic                     nmi_pulse,
  output logic                     ack_error
);
  localparam int GW = $clog2(N_GROUPS);

  src_t [N_GROUPS-1:0] set_v;
  src_t [N_GROUPS-1:0] req;
  src_t [N_GROUPS-1:0] en;
  lvl_t [N_GROUPS-1:0] lvl;
  logic [N_GROUPS-1:0] wr_b0;
  logic [N_GROUPS-1:0] wr_b1;
  logic [N_GROUPS-1:0] cand;
  logic [GW-1:0]       win_grp;
  lvl_t                win_lvl;
  logic [GW-1:0]       acc_grp;

  // Named events for the checker
  logic nmi_evt;
  logic mask_cand_any;
  logic win_is_cand;

  assign set_v = src_set;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    grpint_group #(.IS_NMI(g < N_NMI)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .wr_b0 (wr_b0[g]),
      .wr_b1 (wr_b1[g]),
      .wdata (reg_wdata),
      .req_o (req[g]),
      .en_o  (en[g]),
      .lvl_o (lvl[g])
    );
  end

  grpint_arbiter #(.N(N_GROUPS), .FIRST(N_NMI), .GW(GW)) u_arb (
    .req_i  (req),
    .en_i   (en),
    .lvl_i  (lvl),
    .cand_o (cand),
    .win_o  (win_grp),
    .lvl_o  (win_lvl)
  );

  grpint_regif #(.N(N_GROUPS), .N_NMI(N_NMI), .AW(AW), .GW(GW)) u_reg (
    .reg_en   (reg_en),
    .reg_we   (reg_we),
    .reg_win  (reg_win),
    .reg_addr (reg_addr),
    .req_i    (req),
    .en_i     (en),
    .lvl_i    (lvl),
    .acc_i    (acc_grp),
    .wr_b0    (wr_b0),
    .wr_b1    (wr_b1),
    .rdata    (reg_rdata)
  );

  always_comb begin
    nmi_evt = 1'b0;
    for (int g = 0; g < N_NMI; g++) begin
      if ((|set_v[g]) && (|((req[g] | set_v[g]) & en[g]))) nmi_evt = 1'b1;
    end
  end

  assign mask_cand_any = |cand[N_GROUPS-1:N_NMI];
  assign win_is_cand   = cand[win_grp];
  assign irq_level     = win_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_grp   <= '0;
      nmi_pulse <= 1'b0;
      ack_error <= 1'b0;
    end else begin
      nmi_pulse <= nmi_evt;
      ack_error <= ack_valid && (ack_level != win_lvl);
      if (ack_valid) acc_grp <= win_grp;
    end
  end
endmodule

// File: rtl/grpint_ctrl_chk.sv
module grpint_ctrl_chk #(
  parameter int GW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_valid,
  input logic [2:0]    ack_level,
  input logic [2:0]    irq_level,
  input logic          nmi_pulse,
  input logic          ack_error,
  input logic          reg_en,
  input logic          reg_we,
  input logic          reg_win,
  input logic          mask_cand_any,
  input logic          win_is_cand,
  input logic [GW-1:0] win_grp,
  input logic [GW-1:0] acc_grp,
  input logic          nmi_evt
);
  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_cand_any |-> irq_level == 3'd7);

  a_r2_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd7) |-> win_is_cand);

  a_r10_ack_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> acc_grp == $past(win_grp));

  a_r11_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && (ack_level != irq_level)) |=> ack_error);

  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_valid && (ack_level != irq_level)) |=> !ack_error);

  a_r8_nmi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pulse) |-> $past(nmi_evt));

  a_r12_acc_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_win && !ack_valid) |=> $stable(acc_grp));
endmodule

bind grpint_ctrl grpint_ctrl_chk #(.GW(GW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ack_valid     (ack_valid),
  .ack_level     (ack_level),
  .irq_level     (irq_level),
  .nmi_pulse     (nmi_pulse),
  .ack_error     (ack_error),
  .reg_en        (reg_en),
  .reg_we        (reg_we),
  .reg_win       (reg_win),
  .mask_cand_any (mask_cand_any),
  .win_is_cand   (win_is_cand),
  .win_grp       (win_grp),
  .acc_grp       (acc_grp),
  .nmi_evt       (nmi_evt)
);

// File: tb/grpint_ctrl_bench.sv
`timescale 1ns/1ps
module grpint_ctrl_bench;
  localparam int NG = 25;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [99:0]  src_set = '0;
  logic         ack_valid = 1'b0;
  logic [2:0]   ack_level = '0;
  logic         reg_en = 1'b0;
  logic         reg_we = 1'b0;
  logic         reg_win = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [7:0]   reg_wdata = '0;
  logic [7:0]   reg_rdata;
  logic [2:0]   irq_level;
  logic         nmi_pulse;
  logic         ack_error;

  always #10 clk = ~clk;

  grpint_ctrl u_grpint_ctrl (
    .clk(clk), .rst_n(rst_n), .src_set(src_set),
    .ack_valid(ack_valid), .ack_level(ack_level),
    .reg_en(reg_en), .reg_we(reg_we), .reg_win(reg_win),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .nmi_pulse(nmi_pulse), .ack_error(ack_error)
  );

  typedef struct {
    string tag;
    int    sel;   // 0 level, 1 nmi, 2 error, 3 read data
    int    exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state
  int m_req[NG];
  int m_en[NG];
  int m_lvl[NG];
  int m_acc;

  function automatic int exp_win();
    int best = 7;
    int w = 0;
    for (int g = NG - 1; g >= 2; g--) begin
      if (((m_req[g] & m_en[g]) != 0) && (m_lvl[g] < 7) && (m_lvl[g] <= best)) begin
        best = m_lvl[g];
        w = g;
      end
    end
    return w;
  endfunction

  function automatic int exp_level();
    int w = exp_win();
    return (w == 0) ? 7 : m_lvl[w];
  endfunction

  function automatic void mwrite(int a, int d);
    int g = (a / 4) % NG;
    int b = a % 4;
    if (g < 2) begin
      if (b == 0) m_req[g] = m_req[g] & ~(d & 15);
    end else if (b == 0) begin
      for (int i = 0; i < 4; i++) begin
        bit up = d[4+i];
        bit lo = d[i];
        if (up && lo) m_req[g] = m_req[g] | (1 << i);
        else if (!up && lo) m_req[g] = m_req[g] & ~(1 << i);
      end
    end else if (b == 1) begin
      m_lvl[g] = (d >> 4) & 7;
      m_en[g]  = d & 15;
    end
  endfunction

  task automatic expect_item(string tag, int sel, int exp);
    q.push_back('{tag, sel, exp});
  endtask

  // Monitor: compares every queued item 2 ns after the edge that follows its push
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.sel)
          0:       act = int'(irq_level);
          1:       act = int'(nmi_pulse);
          2:       act = int'(ack_error);
          default: act = int'(reg_rdata);
        endcase
        checks++;
        if (act != it.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic do_set(int g, int s, string tag);
    @(negedge clk);
    src_set[g*4+s] = 1'b1;
    m_req[g] = m_req[g] | (1 << s);
    expect_item(tag, 0, exp_level());
    expect_item(tag, 1, ((g < 2) && ((m_req[g] & m_en[g]) != 0)) ? 1 : 0);
    @(negedge clk);
    src_set = '0;
  endtask

  task automatic do_wr(bit w, int a, int d, string tag);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_win = w;
    reg_addr = 8'(a); reg_wdata = 8'(d);
    if (!w) mwrite(a, d);
    expect_item(tag, 0, exp_level());
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic do_set_wr(int g, int s, int a, int d, string tag);
    @(negedge clk);
    src_set[g*4+s] = 1'b1;
    reg_en = 1'b1; reg_we = 1'b1; reg_win = 1'b0;
    reg_addr = 8'(a); reg_wdata = 8'(d);
    mwrite(a, d);
    m_req[g] = m_req[g] | (1 << s);
    expect_item(tag, 0, exp_level());
    @(negedge clk);
    src_set = '0; reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic do_rd(bit w, int a, int exp, string tag);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_win = w; reg_addr = 8'(a);
    expect_item(tag, 3, exp);
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic do_ack(int l, string tag);
    @(negedge clk);
    ack_valid = 1'b1; ack_level = 3'(l);
    expect_item(tag, 2, (l != exp_level()) ? 1 : 0);
    m_acc = exp_win();
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic do_idle(string tag);
    @(negedge clk);
    expect_item(tag, 1, 0);
    expect_item(tag, 2, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      m_req[g] = 0; m_en[g] = 15; m_lvl[g] = 0;
    end
    m_acc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_item("R1 level", 0, 7);
    expect_item("R1 nmi", 1, 0);
    expect_item("R1 err", 2, 0);
    do_rd(0, 21, 8'h0F, "R1 byte1 default");
    do_rd(0, 20, 8'h00, "R1 byte0 default");

    // R4 / R2 / R5: basic request
    do_set(5, 1, "R4 set g5");
    do_rd(0, 20, 8'h22, "R5 read byte0 g5");

    // R6 level/enable byte
    do_wr(0, 21, 8'h4F, "R6 level 4");
    do_rd(0, 21, 8'h4F, "R6 read byte1");
    do_wr(0, 22, 8'hFF, "R6 byte2 write");
    do_rd(0, 22, 8'h00, "R6 byte2 read");
    do_rd(0, 21, 8'h4F, "R6 byte1 intact");

    // R2 lower level wins
    do_wr(0, 13, 8'h6F, "R2 g3 level 6");
    do_set(3, 0, "R2 g3 pending");

    // R3 tie goes to lower group
    do_wr(0, 29, 8'h4F, "R3 g7 level 4");
    do_set(7, 3, "R3 tie");
    do_ack(4, "R11 matching ack");
    do_rd(1, 0, 8'h14, "R3 R10 accepted g5");

    // R2 masking
    do_wr(0, 21, 8'h40, "R2 g5 disabled");
    do_rd(0, 20, 8'h20, "R5 masked view");
    do_ack(4, "R10 ack g7");
    do_rd(1, 0, 8'h1C, "R10 accepted g7");

    // R11 mismatch
    do_ack(2, "R11 mismatch");
    do_idle("R11 pulse drops");

    // R5 write semantics, R12 lost request
    do_wr(0, 28, 8'h08, "R5 clear bit3");
    do_rd(1, 0, 8'h00, "R12 lost request");
    do_wr(0, 28, 8'h11, "R5 set bit0");
    do_rd(0, 28, 8'h11, "R5 after set");
    do_wr(0, 28, 8'h10, "R5 keep");
    do_rd(0, 28, 8'h11, "R5 keep read");
    do_wr(0, 28, 8'h02, "R5 clear idle bit");
    do_rd(0, 28, 8'h11, "R5 clear idle read");

    // R12 writes ignored
    do_wr(1, 0, 8'hFF, "R12 write");
    do_rd(1, 0, 8'h1C, "R12 after write");
    do_rd(1, 1, 8'h00, "R12 byte1");

    // R7 / R8 non-maskable groups
    do_set(0, 2, "R8 nmi g0");
    do_idle("R8 nmi one cycle");
    do_rd(0, 0, 8'h04, "R7 nmi byte0");
    do_wr(0, 1, 8'h7F, "R7 nmi byte1 write");
    do_rd(0, 1, 8'h00, "R7 nmi byte1 read");
    do_wr(0, 0, 8'h04, "R7 nmi clear");
    do_rd(0, 0, 8'h00, "R7 nmi cleared");
    do_set(1, 0, "R8 nmi g1");
    do_idle("R8 nmi g1 drop");

    // R9 address folding
    do_wr(0, 109, 8'h2F, "R9 alias write g2");
    do_rd(0, 9, 8'h2F, "R9 canonical read");
    do_set(2, 2, "R9 g2 pending");
    do_rd(0, 255, 8'h00, "R9 top offset");
    do_rd(0, 101, 8'h00, "R9 alias nmi byte1");
    do_rd(0, 109, 8'h2F, "R9 alias read");

    // R2 level 7 never selected, R10 default group
    do_wr(0, 97, 8'h7F, "R2 g24 level 7");
    do_set(24, 0, "R2 g24 pending");
    do_wr(0, 9, 8'h20, "R2 g2 off");
    do_wr(0, 13, 8'h60, "R2 g3 off");
    do_wr(0, 29, 8'h40, "R2 g7 off");
    do_ack(7, "R10 idle ack");
    do_rd(1, 0, 8'h00, "R10 default group");

    // R4 set after write in the same cycle
    do_set_wr(10, 0, 40, 8'h01, "R4 set beats clear");
    do_rd(0, 40, 8'h11, "R4 read g10");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule